// File: doc/BRIEF.md
# Self-Clocked Serial Converter Port

This block is the converter side of a three-wire serial link in which the converter makes its own serial clock. The block has three jobs. It models a converter that alternates between converting and sleeping. It reports the conversion status on the data line as soon as the host selects it. After a fixed status-test delay it shifts out a 32-bit result frame on a clock it generates itself, and it collects 24 configuration bits from the host on the same clock. The analog conversion is replaced by a counter that runs for a set number of oscillator cycles and then loads a tagged test word.

The chip-select input is active low and asynchronous, and a two-flop synchroniser retimes it. The clock pin is shared with the outside world. On each selection the block decides whether to drive the clock by looking at the resolved level of that pin. That level depends on any external driver or resistor, and on an internal weak pull-up, which switches off whenever the pin has been left low. Raising chip select during the status test sends the converter back to sleep and keeps its result. Raising it during a frame aborts the frame and starts a new conversion.

Top module: `self_clk_adc_port`

## Requirements
- R1: At each synchronised falling edge of cs_ni, the block samples the clock-pin level. This level is sck_ext_i when sck_ext_oe_i is 1. Otherwise it is sck_ext_i OR the internal pull-up state. If the level is high, the block drives SCK (sck_oe_o and sdo_oe_o go to 1). If it is low, sck_oe_o and sdo_oe_o stay 0 until cs_ni rises.
- R2: sdo_oe_o is 0 whenever the synchronised cs_ni has been high for two cycles.
- R3: On selection, sdo_oe_o and sck_oe_o rise in the third clock after cs_ni falls, with sck_o low. sdo_o then shows the status: 1 while a conversion runs, 0 when asleep.
- R4: The first sck_o rising edge comes TEST_DLY cycles after sdo_o shows 0. That is TEST_DLY+3 cycles after cs_ni falls when the converter was asleep, and TEST_DLY cycles after the status drops while the port is selected.
- R5: If cs_ni rises before the first SCK rising edge, no SCK rising edge occurs, the converter returns to sleep, and the next frame carries the same result word.
- R6: A frame has 32 SCK rising edges, each 2*HALF_PER cycles after the one before. sdo_o changes only on SCK falling edges. The bit seen at rising edge k is bit 32-k of the word {1'b0, RES_TAG[30:8], idx[7:0]}, so the first bit is the status 0.
- R7: After the 32nd rising edge, sdo_o is 1 and sck_o stays high. A new conversion finishes CONV_CYCLES cycles later, which with cs_ni still low drops sdo_o to 0.
- R8: SDI is sampled on each SCK rising edge, including the first. The first sampled bit becomes cfg_o[23]. cfg_o changes only at the 24th rising edge, and only to the 24 bits captured.
- R9: Raising cs_ni mid-frame aborts the frame and starts a conversion. cfg_o is unchanged if fewer than 24 rising edges had occurred, and holds the new bits otherwise.
- R10: An abort taken while SCK is driven low switches the internal pull-up off. With no external pull, the next selection is refused. Once the undriven pin has been seen high, selection works again.
- R11: idx starts at 0 after reset and increments at every completed conversion. The first conversion completes CONV_CYCLES cycles after reset.
- R12: After reset, sdo_oe_o and sck_oe_o are 0 and cfg_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sdi_i | input | 1 | Serial configuration data from host |
| sck_ext_oe_i | input | 1 | An external agent is driving the clock pin |
| sck_ext_i | input | 1 | External drive level, or, when not driving, 1 if an external resistor pulls the pin high |
| sck_o | output | 1 | Generated serial clock level |
| sck_oe_o | output | 1 | Block drives the clock pin |
| sdo_o | output | 1 | Serial data / status output |
| sdo_oe_o | output | 1 | Data output enable; low means high impedance |
| cfg_o | output | 24 | Committed configuration word |

## Verification
The bench times the first clock edge from both entry paths: selection while asleep, and the status dropping while already selected. A design that counted the delay from the wrong event would show a shifted latency. Aborts are placed just before and just after the 24th rising edge. A design that committed configuration early, or that dropped bits already loaded, would leave the wrong word on cfg_o. The bench also aborts while SCK is low and then reselects with no pull. A design that kept its pull-up on would wrongly take the port again, and one that never restored the pull-up would refuse it after the pin had been pulled high. A status test cut short must leave the next frame carrying the unchanged result word.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SHIFT = 2'd3
  } adc_state_e;
endpackage

// File: rtl/adc_cs_sync.sv
module adc_cs_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= 2'b11;
    else         ff_q <= {ff_q[0], async_i};
  end

  assign sync_o = ff_q[1];
endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int unsigned HALF_PER = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PH_W = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;

  logic [PH_W-1:0] ph_q;

  assign tick_o = run_i && (ph_q == PH_W'(HALF_PER - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ph_q <= '0;
    else if (!run_i || tick_o)  ph_q <= '0;
    else                        ph_q <= ph_q + PH_W'(1);
  end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned CFG_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_val_i,
  input  logic               shift_i,
  input  logic               cap_i,
  input  logic               commit_i,
  input  logic               sdi_i,
  output logic               msb_o,
  output logic [CFG_W-1:0]   cfg_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CFG_W-2:0]   cfg_sh_q;
  logic [CFG_W-1:0]   cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cfg_sh_q <= '0;
      cfg_q    <= '0;
    end else begin
      if (load_i)       sh_q <= load_val_i;
      else if (shift_i) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
      if (cap_i)    cfg_sh_q <= {cfg_sh_q[CFG_W-3:0], sdi_i};
      if (commit_i) cfg_q    <= {cfg_sh_q, sdi_i};
    end
  end

  assign msb_o = sh_q[FRAME_W-1];
  assign cfg_o = cfg_q;
endmodule

// File: rtl/self_clk_adc_port.sv
module self_clk_adc_port
  import adc_port_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 64,
  parameter int unsigned TEST_DLY    = 4,
  parameter int unsigned HALF_PER    = 2,
  parameter int unsigned FRAME_W     = 32,
  parameter int unsigned CFG_W       = 24,
  parameter int unsigned IDX_W       = 8,
  parameter logic [FRAME_W-1:0] RES_TAG = 32'hC3A5_96F0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sdi_i,
  input  logic             sck_ext_oe_i,
  input  logic             sck_ext_i,
  output logic             sck_o,
  output logic             sck_oe_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int unsigned CONV_W = $clog2(CONV_CYCLES + 1);
  localparam int unsigned DLY_W  = $clog2(TEST_DLY + 1);
  localparam int unsigned BIT_W  = $clog2(FRAME_W + 1);

  adc_state_e        state_q;
  logic [CONV_W-1:0] conv_cnt_q;
  logic [DLY_W-1:0]  dly_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              sel_q, sck_q, pu_q, cs_d_q;
  logic              cs_n_s, cs_fall, cs_rise, line_lvl, sel_set;
  logic              tick, rise_ev, fall_ev, commit, conv_done, dly_done, msb;
  logic [FRAME_W-1:0] load_val;

  adc_cs_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(cs_ni),
    .sync_o (cs_n_s)
  );

  adc_sck_gen #(.HALF_PER(HALF_PER)) u_sck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_SHIFT),
    .tick_o(tick)
  );

  assign cs_fall   = cs_d_q && !cs_n_s;
  assign cs_rise   = !cs_d_q && cs_n_s;
  // weak pull-up only helps when nobody drives the pin
  assign line_lvl  = sck_ext_oe_i ? sck_ext_i : (sck_ext_i | pu_q);
  assign sel_set   = cs_fall && line_lvl;
  assign conv_done = (state_q == ST_CONV) && (conv_cnt_q == CONV_W'(CONV_CYCLES - 1));
  assign dly_done  = dly_q == DLY_W'(TEST_DLY - 1);
  assign rise_ev   = !cs_rise && (((state_q == ST_WAIT) && dly_done) ||
                                  ((state_q == ST_SHIFT) && tick && !sck_q));
  assign fall_ev   = !cs_rise && (state_q == ST_SHIFT) && tick && sck_q;
  assign commit    = rise_ev && (bit_cnt_q == BIT_W'(CFG_W - 1));
  assign load_val  = {1'b0, RES_TAG[FRAME_W-2:IDX_W], idx_q + IDX_W'(1)};

  adc_frame_shift #(.FRAME_W(FRAME_W), .CFG_W(CFG_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (conv_done),
    .load_val_i(load_val),
    .shift_i   (fall_ev),
    .cap_i     (rise_ev),
    .commit_i  (commit),
    .sdi_i     (sdi_i),
    .msb_o     (msb),
    .cfg_o     (cfg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CONV;
      conv_cnt_q <= '0;
      dly_q      <= '0;
      bit_cnt_q  <= '0;
      idx_q      <= '0;
      sel_q      <= 1'b0;
      sck_q      <= 1'b1;
      pu_q       <= 1'b1;
      cs_d_q     <= 1'b1;
    end else begin
      cs_d_q <= cs_n_s;

      if (cs_rise)      sel_q <= 1'b0;
      else if (sel_set) sel_q <= 1'b1;

      // pull-up tracks the last pin level; abort with SCK low leaves it off
      if (cs_rise)    pu_q <= (state_q == ST_SHIFT) ? sck_q : 1'b1;
      else if (sel_q) pu_q <= sck_q;
      else            pu_q <= line_lvl;

      if (sel_set) sck_q <= 1'b0;

      case (state_q)
        ST_CONV: begin
          if (conv_done) begin
            conv_cnt_q <= '0;
            idx_q      <= idx_q + IDX_W'(1);
            if ((sel_q || sel_set) && !cs_rise) begin
              state_q   <= ST_WAIT;
              dly_q     <= '0;
              bit_cnt_q <= '0;
              sck_q     <= 1'b0;
            end else begin
              state_q <= ST_SLEEP;
            end
          end else begin
            conv_cnt_q <= conv_cnt_q + CONV_W'(1);
          end
        end
        ST_SLEEP: begin
          if (sel_set) begin
            state_q   <= ST_WAIT;
            dly_q     <= '0;
            bit_cnt_q <= '0;
          end
        end
        ST_WAIT: begin
          if (cs_rise) begin
            state_q <= ST_SLEEP;
          end else if (dly_done) begin
            state_q   <= ST_SHIFT;
            sck_q     <= 1'b1;
            bit_cnt_q <= BIT_W'(1);
          end else begin
            dly_q <= dly_q + DLY_W'(1);
          end
        end
        ST_SHIFT: begin
          if (cs_rise) begin
            state_q    <= ST_CONV;
            conv_cnt_q <= '0;
          end else if (tick) begin
            if (sck_q) begin
              sck_q <= 1'b0;
            end else begin
              sck_q     <= 1'b1;
              bit_cnt_q <= bit_cnt_q + BIT_W'(1);
              if (bit_cnt_q == BIT_W'(FRAME_W - 1)) begin
                state_q    <= ST_CONV;
                conv_cnt_q <= '0;
              end
            end
          end
        end
        default: state_q <= ST_CONV;
      endcase
    end
  end

  assign sck_o    = sck_q;
  assign sck_oe_o = sel_q;
  assign sdo_oe_o = sel_q;
  assign sdo_o    = (state_q == ST_CONV) ? 1'b1 : msb;
endmodule

// File: rtl/adc_port_chk.sv
module adc_port_chk #(
  parameter int unsigned CFG_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_n_s_i,
  input logic             sck_i,
  input logic             sck_oe_i,
  input logic             sdo_i,
  input logic             sdo_oe_i,
  input logic [CFG_W-1:0] cfg_i
);
  a_r2_sdo_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_s_i && $past(cs_n_s_i)) |-> !sdo_oe_i);

  a_r3_sck_low_on_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_oe_i) |-> !sck_i);

  a_r6_sdo_holds_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_i && $past(sck_i) && sck_oe_i && $past(sck_oe_i)) |-> $stable(sdo_i));

  a_r8_cfg_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_i) |-> ($rose(sck_i) && sck_oe_i));
endmodule

bind self_clk_adc_port adc_port_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_n_s_i(cs_n_s),
  .sck_i   (sck_o),
  .sck_oe_i(sck_oe_o),
  .sdo_i   (sdo_o),
  .sdo_oe_i(sdo_oe_o),
  .cfg_i   (cfg_o)
);

// File: tb/sim_self_clk_adc_port.sv
`timescale 1ns/1ps
module sim_self_clk_adc_port;
  localparam int CONV = 64;
  localparam int TD   = 4;
  localparam int HALF = 2;
  localparam logic [31:0] TAG = 32'hC3A5_96F0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sdi = 1'b0, ext_oe = 1'b0, ext = 1'b0;
  logic sck, sck_oe, sdo, sdo_oe;
  logic [23:0] cfg;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  self_clk_adc_port #(.CONV_CYCLES(CONV), .TEST_DLY(TD), .HALF_PER(HALF), .RES_TAG(TAG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sdi_i(sdi),
    .sck_ext_oe_i(ext_oe), .sck_ext_i(ext),
    .sck_o(sck), .sck_oe_o(sck_oe), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_o(cfg)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int i);
    logic [7:0] lo = i[7:0];
    return {1'b0, TAG[30:8], lo};
  endfunction

  logic [31:0] f_word;
  int f_rises, f_n_oe, f_n_low, f_n_r1, f_stray, f_badgap;

  // host receiver: watches SCK, returns after 32 rises or abort_k rises
  task automatic run_frame(input int abort_k, input logic [23:0] cfgv);
    int n = 0, last_r = 0;
    logic prev_sck = sck, prev_sdo = sdo, prev_oe = sdo_oe, last_low = sdo;
    logic rise, fall;
    f_word = '0; f_rises = 0; f_n_oe = -1; f_n_low = -1; f_n_r1 = -1;
    f_stray = 0; f_badgap = 0;
    sdi = cfgv[23];
    while (n < 3000) begin
      @(negedge clk); n++;
      if (sdo_oe && f_n_oe < 0) f_n_oe = n;
      if (sdo_oe && !sdo && f_n_low < 0) f_n_low = n;
      rise = sck_oe && sck && !prev_sck;
      fall = prev_sck && !sck;
      if (rise) begin
        f_rises++;
        f_word = {f_word[30:0], last_low};
        if (f_rises == 1) f_n_r1 = n;
        else if (n - last_r != 2*HALF) f_badgap++;
        last_r = n;
      end
      if (prev_oe && sdo_oe && sdo != prev_sdo && !fall && !(rise && f_rises == 32)) f_stray++;
      if (fall) sdi = (f_rises < 24) ? cfgv[23-f_rises] : 1'b0;
      if (!sck) last_low = sdo;
      prev_sck = sck; prev_sdo = sdo; prev_oe = sdo_oe;
      if (rise && abort_k > 0 && f_rises == abort_k) begin
        cs_n = 1'b1;
        break;
      end
      if (rise && f_rises == 32) break;
    end
    chk(n < 3000, "frame timeout", n, 3000);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic watch_refused(input string req);
    int seen = 0;
    cs_n = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sdo_oe || sck_oe) seen++;
    end
    chk(seen == 0, req, seen, 0);
    cs_n = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sdo_oe && !sck_oe, "R12 enables after reset", {sdo_oe, sck_oe}, 0);
    chk(cfg == 24'h0, "R12 cfg after reset", cfg, 0);
    idle(100); // conversion 1 done -> idx 1 (R11)

    // R3/R4/R6/R8: select while asleep
    cs_n = 1'b0;
    run_frame(0, 24'hA5C3E1);
    chk(f_n_oe == 3, "R3 select latency", f_n_oe, 3);
    chk(f_n_low == 3, "R3 status 0 when asleep", f_n_low, 3);
    chk(f_n_r1 == TD + 3, "R4 first rise after cs fall", f_n_r1, TD + 3);
    chk(f_rises == 32, "R6 rise count", f_rises, 32);
    chk(f_word == exp_word(1), "R6 frame word idx1", f_word, exp_word(1));
    chk(f_badgap == 0, "R6 SCK period", f_badgap, 0);
    chk(f_stray == 0, "R6 SDO moves only on falls", f_stray, 0);
    chk(sck && sdo && sdo_oe, "R7 idle levels after frame", {sck, sdo, sdo_oe}, 3'b111);
    chk(cfg == 24'hA5C3E1, "R8 cfg committed", cfg, 24'hA5C3E1);

    // R7/R11/R4: stay selected, next conversion ends and status drops
    run_frame(0, 24'h3C5A96);
    chk(f_n_low == CONV, "R7 R11 conversion time", f_n_low, CONV);
    chk(f_n_r1 == CONV + TD, "R4 first rise after status drop", f_n_r1, CONV + TD);
    chk(f_word == exp_word(2), "R11 frame word idx2", f_word, exp_word(2));
    chk(f_stray == 0, "R6 SDO stable second frame", f_stray, 0);
    chk(cfg == 24'h3C5A96, "R8 cfg second frame", cfg, 24'h3C5A96);
    cs_n = 1'b1;
    idle(80); // idx 3
    chk(!sdo_oe, "R2 released with cs high", sdo_oe, 0);

    // R5: status test cut short
    cs_n = 1'b0;
    idle(2);
    cs_n = 1'b1;
    idle(2);
    chk(sdo_oe && sck_oe && !sck, "R5 selected, SCK still low", {sdo_oe, sck_oe, sck}, 3'b110);
    idle(8);
    chk(!sdo_oe && !sck_oe, "R2 R5 released after short test", {sdo_oe, sck_oe}, 0);
    cs_n = 1'b0;
    run_frame(0, 24'h0F0F0F);
    chk(f_word == exp_word(3), "R5 result kept", f_word, exp_word(3));
    chk(f_n_r1 == TD + 3, "R5 reselect after short test", f_n_r1, TD + 3);
    cs_n = 1'b1;
    idle(80); // idx 4

    // R9/R10: abort after 10 rises with SCK low
    cs_n = 1'b0;
    run_frame(10, 24'h123456);
    chk(f_rises == 10, "R9 abort point", f_rises, 10);
    idle(80); // idx 5
    chk(cfg == 24'h0F0F0F, "R9 early abort keeps cfg", cfg, 24'h0F0F0F);
    watch_refused("R10 refused with pull-up off");
    ext = 1'b1;
    idle(2);
    ext = 1'b0;
    idle(2);
    cs_n = 1'b0;
    run_frame(0, 24'h5A5A5A);
    chk(f_n_r1 == TD + 3, "R10 accepted after pin seen high", f_n_r1, TD + 3);
    chk(f_word == exp_word(5), "R9 new conversion after abort", f_word, exp_word(5));
    cs_n = 1'b1;
    idle(80); // idx 6

    // R9: abort after the 24th rise
    cs_n = 1'b0;
    run_frame(24, 24'hC0FFEE);
    idle(80); // idx 7
    chk(cfg == 24'hC0FFEE, "R9 late abort keeps new cfg", cfg, 24'hC0FFEE);

    // R1: external driver decides the mode
    ext_oe = 1'b1; ext = 1'b1;
    idle(2);
    ext = 1'b0;
    idle(2);
    watch_refused("R1 refused with pin driven low");
    ext = 1'b1;
    idle(2);
    cs_n = 1'b0;
    run_frame(0, 24'h000001);
    chk(f_n_r1 == TD + 3, "R1 accepted with pin driven high", f_n_r1, TD + 3);
    chk(f_word == exp_word(7), "R1 frame word idx7", f_word, exp_word(7));
    cs_n = 1'b1;
    ext_oe = 1'b0; ext = 1'b0;
    idle(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule